// File: doc/BRIEF.md
# Programmable GF(2) Modular Multiplier

This block multiplies two polynomials over GF(2) and reduces the product modulo a generator polynomial of degree 1 to 32 that can be changed while the chip runs. The generator is not wired in as an XOR tree. It is held as a reduction matrix that is written row by row through a write port. Row `j` holds `x^(d+j) mod p`, where `d` is the degree presented with each operation. The first pipeline stage forms the carry-less product. The second stage passes the product bits at or above `x^d` through a vector-matrix multiply and XORs in the product bits below `x^d` unchanged.

A mode input splits each 32-bit word into four byte lanes. In that mode the matching bytes of the two factors are multiplied on their own, and each lane product is reduced independently. The same matrix datapath serves both modes; only the loaded matrix differs. In lane mode the matrix may hold a different generator for each lane, provided all lanes share one degree. Typical use is in a checksum engine: it builds powers of `x` by feeding results back as factors, and it scales data words by those powers.

Top module: `gf2_modmul`

## Requirements
- R1: In word mode (`simd_en`=0) with `degree` d in 1..32, and both factors of degree below d, `result` equals the carry-less product `fa·fb` reduced modulo p. This holds when matrix row j (0..30) holds the coefficients of `x^(d+j) mod p`, with bit k of the row being the coefficient of `x^k`. A zero factor always gives a zero result. A factor of 1 returns the other factor unchanged.
- R2: In lane mode (`simd_en`=1) with d in 1..8, byte L of `result` (bits 8L+7..8L) equals the product of byte L of `fa` and byte L of `fb`, reduced modulo that lane's generator p_L. This holds when matrix row 7L+j (j in 0..6) holds `x^(d+j) mod p_L` in its bits 8L+7..8L and zeros elsewhere. Rows 28..30 are unused.
- R3: An operation presented with `in_valid` in cycle n appears with `out_valid` in cycle n+2. A new operation may be accepted every cycle, and results leave in issue order.
- R4: Result bits at or above the degree are zero. In lane mode this applies inside each byte, and a degree above 8 acts as 8. A degree of 0 gives an all-zero result.
- R5: While `out_valid` is low, `result` is zero. This includes the reset state.
- R6: A matrix row written with `mat_we` in the same cycle as an issue applies to that operation. A row written in any later cycle does not change the result of an operation already issued.
- R7: A write with `mat_row` = 31 changes no row of the matrix.
- R8: Reset clears every matrix row. Until rows are loaded, the result is only the product bits below the degree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue an operation this cycle |
| simd_en | input | 1 | 0: one 32-bit product; 1: four byte-lane products |
| degree | input | 6 | Generator degree d for this operation |
| fa | input | 32 | First factor |
| fb | input | 32 | Second factor |
| mat_we | input | 1 | Write one matrix row this cycle |
| mat_row | input | 5 | Row index of the write (0..30) |
| mat_data | input | 32 | Row contents |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Reduced product |

## Verification
In word mode, random generators of degree 1, 8, 17, 24, 31 and 32 are paired with random reduced factors and checked against bit-serial long division. A wrong row offset or a wrong shift of the high product by the degree shows up at some degree other than 32. With an empty matrix after reset, the product x^31·x^31 separates the low-part path from the matrix path. Single-term products such as x^62 and x^32 pick out individual rows, which exposes write-timing and row-decode faults. In lane mode each byte lane gets its own random generator, so any leak of partial products or high bits between lanes corrupts a neighbour. A degree above 8 checks the per-lane clamp, and unreduced all-ones factors check the masking above the degree.

// File: rtl/gf2_modmul_pkg.sv
package gf2_modmul_pkg;

   typedef enum logic {
      MODE_WORD  = 1'b0,
      MODE_LANES = 1'b1
   } mode_e;

   // Ones in every position below n (n clipped to 64).
   function automatic logic [63:0] low_ones(input int n);
      if (n >= 64) return '1;
      return (64'h1 << n) - 64'h1;
   endfunction

endpackage

// File: rtl/gf2_clmul.sv
// Carry-less multiply; in lane mode only partial products whose factor
// bits lie in the same lane are summed, so lane L lands in bits 2*LW*L up.
module gf2_clmul #(
   parameter int W  = 32,
   parameter int LW = 8
) (
   input  logic [W-1:0]   fa,
   input  logic [W-1:0]   fb,
   input  logic           lanes,
   output logic [2*W-2:0] prod
);

   always_comb begin
      prod = '0;
      for (int i = 0; i < W; i++) begin
         for (int j = 0; j < W; j++) begin
            if (!lanes || ((i / LW) == (j / LW))) begin
               prod[i + j] = prod[i + j] ^ (fa[i] & fb[j]);
            end
         end
      end
   end

endmodule

// File: rtl/gf2_split.sv
// Splits a product into the high part fed to the matrix and the low part
// kept as is, for either the full word or each byte lane.
module gf2_split
   import gf2_modmul_pkg::*;
#(
   parameter int W     = 32,
   parameter int LANES = 4
) (
   input  logic [2*W-2:0]           prod,
   input  logic                     lanes,
   input  logic [$clog2(W+1)-1:0]   deg,
   output logic [W-2:0]             th,
   output logic [W-1:0]             tl,
   output logic [W-1:0]             keep
);

   localparam int LW  = W / LANES;
   localparam int LR  = LW - 1;
   localparam int R   = W - 1;
   localparam int PW  = 2 * W - 1;
   localparam int LPW = 2 * LW - 1;
   localparam int DGW = $clog2(W + 1);

   logic [R-1:0] th_w, th_l;
   logic [W-1:0] tl_w, tl_l, keep_w, keep_l;

   always_comb begin
      for (int j = 0; j < R; j++) begin
         th_w[j] = ((int'(deg) + j) < PW) ? prod[int'(deg) + j] : 1'b0;
      end
      keep_w = W'(low_ones(int'(deg)));
      tl_w   = prod[W-1:0] & keep_w;
   end

   for (genvar L = 0; L < LANES; L++) begin : g_lane
      logic [LPW-1:0] lp;
      logic [DGW-1:0] ed;
      logic [LW-1:0]  lk;

      assign lp = prod[2*LW*L +: LPW];
      assign ed = (deg > DGW'(LW)) ? DGW'(LW) : deg;
      assign lk = LW'(low_ones(int'(ed)));

      always_comb begin
         for (int j = 0; j < LR; j++) begin
            th_l[L*LR + j] = ((int'(ed) + j) < LPW) ? lp[int'(ed) + j] : 1'b0;
         end
      end

      assign tl_l[L*LW +: LW]   = lp[LW-1:0] & lk;
      assign keep_l[L*LW +: LW] = lk;
   end

   if (LANES * LR < R) begin : g_spare_rows
      assign th_l[R-1:LANES*LR] = '0;
   end

   assign th   = lanes ? th_l   : th_w;
   assign tl   = lanes ? tl_l   : tl_w;
   assign keep = lanes ? keep_l : keep_w;

endmodule

// File: rtl/gf2_rowmat.sv
// Reduction matrix storage (W-1 rows of W bits) and the vector-matrix multiply.
module gf2_rowmat #(
   parameter int W = 32
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      we,
   input  logic [(((W-1) > 1) ? $clog2(W-1) : 1)-1:0] row,
   input  logic [W-1:0]                              wdata,
   input  logic [W-2:0]                              th,
   output logic [W-1:0]                              y
);

   localparam int R   = W - 1;
   localparam int RAW = (R > 1) ? $clog2(R) : 1;

   logic [W-1:0] rows [R];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < R; r++) rows[r] <= '0;
      end else begin
         for (int r = 0; r < R; r++) begin
            if (we && (row == RAW'(r))) rows[r] <= wdata;
         end
      end
   end

   always_comb begin
      y = '0;
      for (int r = 0; r < R; r++) begin
         y = y ^ (rows[r] & {W{th[r]}});
      end
   end

endmodule

// File: rtl/gf2_modmul.sv
module gf2_modmul
   import gf2_modmul_pkg::*;
#(
   parameter int  W     = 32,
   parameter int  LANES = 4,
   localparam int PW    = 2 * W - 1,
   localparam int R     = W - 1,
   localparam int DGW   = $clog2(W + 1),
   localparam int RAW   = (R > 1) ? $clog2(R) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic           simd_en,
   input  logic [DGW-1:0] degree,
   input  logic [W-1:0]   fa,
   input  logic [W-1:0]   fb,
   input  logic           mat_we,
   input  logic [RAW-1:0] mat_row,
   input  logic [W-1:0]   mat_data,
   output logic           out_valid,
   output logic [W-1:0]   result
);

   localparam int LW = W / LANES;

   if (W % LANES != 0) begin : g_chk_div
      $error("W must be a multiple of LANES");
   end
   if (LW < 2) begin : g_chk_lw
      $error("each lane needs at least two bits");
   end
   if (W > 64 || W < 4) begin : g_chk_w
      $error("W must lie in 4..64");
   end

   // Stage 1: carry-less product
   logic [PW-1:0]  prod_c, s1_prod;
   logic           s1_v;
   mode_e          s1_mode;
   logic [DGW-1:0] s1_deg;

   gf2_clmul #(.W(W), .LW(LW)) u_clmul (
      .fa    (fa),
      .fb    (fb),
      .lanes (simd_en),
      .prod  (prod_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_mode <= MODE_WORD;
         s1_deg  <= '0;
         s1_prod <= '0;
      end else begin
         s1_v    <= in_valid;
         s1_mode <= simd_en ? MODE_LANES : MODE_WORD;
         s1_deg  <= degree;
         s1_prod <= prod_c;
      end
   end

   // Stage 2: reduction of the high part, low part added
   logic [R-1:0] th;
   logic [W-1:0] tl, keep, y, red;

   gf2_split #(.W(W), .LANES(LANES)) u_split (
      .prod  (s1_prod),
      .lanes (s1_mode == MODE_LANES),
      .deg   (s1_deg),
      .th    (th),
      .tl    (tl),
      .keep  (keep)
   );

   gf2_rowmat #(.W(W)) u_mat (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mat_we),
      .row   (mat_row),
      .wdata (mat_data),
      .th    (th),
      .y     (y)
   );

   assign red = (y ^ tl) & keep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= s1_v;
         result    <= s1_v ? red : '0;
      end
   end

endmodule

// File: rtl/gf2_modmul_chk.sv
module gf2_modmul_chk #(
   parameter int W     = 32,
   parameter int LANES = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic                   simd_en,
   input logic [$clog2(W+1)-1:0] degree,
   input logic [W-1:0]           fa,
   input logic [W-1:0]           fb,
   input logic                   out_valid,
   input logic [W-1:0]           result
);

   localparam int LW  = W / LANES;
   localparam int DGW = $clog2(W + 1);

   function automatic logic [W-1:0] allowed(input logic ln, input logic [DGW-1:0] d);
      logic [W-1:0] m;
      int e;
      m = '0;
      e = (int'(d) > LW) ? LW : int'(d);
      for (int k = 0; k < W; k++) begin
         m[k] = ln ? ((k % LW) < e) : (k < int'(d));
      end
      return m;
   endfunction

   // R3: every issue produces a result two cycles later
   a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);

   // R3: no result without an issue
   a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##2 !out_valid);

   // R5: idle output is zero
   a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (result == '0));

   // R4: nothing at or above the degree
   a_r4_above_degree: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((result & ~allowed($past(simd_en, 2), $past(degree, 2))) == '0));

   // R1: zero factor gives zero
   a_r1_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (fa == '0)) |-> ##2 (result == '0));

   // R1: unit factor passes the reduced other factor through
   a_r1_unit_factor: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !simd_en && (fb == W'(1)) && (degree != '0) && ((fa >> degree) == '0))
      |-> ##2 (result == $past(fa, 2)));

endmodule

bind gf2_modmul gf2_modmul_chk #(.W(W), .LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .simd_en   (simd_en),
   .degree    (degree),
   .fa        (fa),
   .fb        (fb),
   .out_valid (out_valid),
   .result    (result)
);

// File: tb/gf2_modmul_test.sv
`timescale 1ns/1ps
module gf2_modmul_test;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        in_valid = 1'b0, simd_en = 1'b0, mat_we = 1'b0;
   logic [5:0]  degree = '0;
   logic [31:0] fa = '0, fb = '0, mat_data = '0;
   logic [4:0]  mat_row = '0;
   logic        out_valid;
   logic [31:0] result;

   int checks = 0, fails = 0, cyc = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] ex;
      logic [31:0] msk;
      int          cyc;
      int          req;
   } item_t;
   item_t q[$];

   gf2_modmul uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .simd_en(simd_en),
      .degree(degree), .fa(fa), .fb(fb), .mat_we(mat_we), .mat_row(mat_row),
      .mat_data(mat_data), .out_valid(out_valid), .result(result)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // ---------------- reference model ----------------
   function automatic logic [31:0] lowm(input int d);
      if (d >= 32) return 32'hFFFF_FFFF;
      return (32'h1 << d) - 32'h1;
   endfunction

   function automatic logic [63:0] clm(input logic [31:0] a, input logic [31:0] b);
      logic [63:0] r;
      r = '0;
      for (int i = 0; i < 32; i++) if (a[i]) r = r ^ ({32'h0, b} << i);
      return r;
   endfunction

   // bit-serial long division
   function automatic logic [31:0] pmod(input logic [63:0] v, input int d, input logic [32:0] p);
      logic [63:0] t;
      t = v;
      for (int k = 63; k >= d; k--) if (t[k]) t = t ^ ({31'h0, p} << (k - d));
      return t[31:0] & lowm(d);
   endfunction

   function automatic logic [31:0] lref(input logic [31:0] a, input logic [31:0] b,
                                        input int d, input logic [32:0] pl [4]);
      logic [31:0] r;
      for (int l = 0; l < 4; l++)
         r[8*l +: 8] = 8'(pmod(clm({24'h0, a[8*l +: 8]}, {24'h0, b[8*l +: 8]}), d, pl[l]));
      return r;
   endfunction

   function automatic logic [32:0] rndp(input int d);
      return (33'h1 << d) | {1'b0, $urandom() & lowm(d)};
   endfunction

   // ---------------- checks ----------------
   task automatic chk(input bit ok, input int req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard in order (R3 latency, R5 idle zero)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (q.size() == 0) begin
               chk(1'b0, 3, "result without issue", result, 32'h0);
            end else begin
               item_t it;
               it = q.pop_front();
               chk((result & it.msk) == it.ex, it.req, "result", result & it.msk, it.ex);
               chk(cyc == it.cyc + 2, 3, "latency", 32'(cyc - it.cyc), 32'd2);
            end
         end else begin
            chk(result == 32'h0, 5, "idle result", result, 32'h0);
         end
      end
   end

   // ---------------- driver ----------------
   task automatic drv(input bit iv, input bit sm, input int d, input logic [31:0] a,
                      input logic [31:0] b, input bit we, input int row, input logic [31:0] wd,
                      input logic [31:0] ex, input logic [31:0] msk, input int req);
      @(negedge clk);
      in_valid = iv; simd_en = sm; degree = 6'(d); fa = a; fb = b;
      mat_we = we; mat_row = 5'(row); mat_data = wd;
      if (iv) q.push_back('{ex, msk, cyc, req});
   endtask

   task automatic idle();
      drv(1'b0, 1'b0, 0, '0, '0, 1'b0, 0, '0, '0, '0, 0);
   endtask

   task automatic wr(input int row, input logic [31:0] wd);
      drv(1'b0, 1'b0, 0, '0, '0, 1'b1, row, wd, '0, '0, 0);
   endtask

   task automatic load_word(input int d, input logic [32:0] p);
      for (int j = 0; j < 31; j++) wr(j, pmod(64'h1 << (d + j), d, p));
   endtask

   task automatic load_lanes(input int d, input logic [32:0] pl [4]);
      for (int r = 0; r < 31; r++) begin
         int l, j;
         l = r / 7; j = r % 7;
         if (l < 4) wr(r, {24'h0, 8'(pmod(64'h1 << (d + j), d, pl[l]))} << (8 * l));
         else       wr(r, 32'h0);
      end
   endtask

   // ---------------- stimulus ----------------
   initial begin
      int dw[6] = '{32, 1, 8, 17, 31, 24};
      int dl[4] = '{8, 3, 1, 5};
      logic [32:0] p;
      logic [32:0] pl [4];
      logic [31:0] r0, r30;

      repeat (3) @(negedge clk);
      // R5: reset state
      chk(out_valid == 1'b0, 5, "out_valid in reset", {31'h0, out_valid}, 32'h0);
      chk(result == 32'h0, 5, "result in reset", result, 32'h0);
      rst_n = 1'b1;

      // R8: empty matrix leaves only the low part
      drv(1, 0, 32, 32'h8000_0001, 32'h8000_0001, 0, 0, '0, 32'h0000_0001, '1, 8);
      drv(1, 0, 32, 32'h8000_0000, 32'h0001_0003, 0, 0, '0, 32'h8000_0000, '1, 8);
      idle();

      // R1: random generators and factors, back-to-back issue (R3)
      foreach (dw[k]) begin
         int d;
         d = dw[k];
         p = rndp(d);
         load_word(d, p);
         for (int n = 0; n < 16; n++) begin
            logic [31:0] a, b;
            a = $urandom() & lowm(d);
            b = $urandom() & lowm(d);
            drv(1, 0, d, a, b, 0, 0, '0, pmod(clm(a, b), d, p), '1, 1);
         end
      end
      // R4: unreduced factors keep bits at/above degree 24 clear; degree 0 gives zero
      drv(1, 0, 24, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, '0, 32'h0, ~lowm(24), 4);
      drv(1, 0, 0, 32'h1234_5678, 32'h9ABC_DEF1, 0, 0, '0, 32'h0, '1, 4);
      idle();

      // R6 / R7: write timing and ignored row index
      p = rndp(32);
      load_word(32, p);
      r30 = pmod(64'h1 << 62, 32, p);
      r0  = pmod(64'h1 << 32, 32, p);
      drv(1, 0, 32, 32'h8000_0000, 32'h8000_0000, 0, 0,  '0,           r30,          '1, 6);
      drv(1, 0, 32, 32'h8000_0000, 32'h8000_0000, 1, 30, 32'h1234_5678, 32'h1234_5678, '1, 6);
      drv(1, 0, 32, 32'h8000_0000, 32'h8000_0000, 1, 31, 32'hFFFF_FFFF, 32'h1234_5678, '1, 7);
      drv(1, 0, 32, 32'h8000_0000, 32'h0000_0002, 0, 0,  '0,           r0,           '1, 7);
      drv(1, 0, 32, 32'h8000_0000, 32'h8000_0000, 0, 0,  '0,           32'h1234_5678, '1, 7);
      idle();

      // R2: four independent byte lanes
      foreach (dl[k]) begin
         int d;
         logic [31:0] lm;
         d = dl[k];
         for (int l = 0; l < 4; l++) pl[l] = rndp(d);
         load_lanes(d, pl);
         lm = {4{8'(lowm(d))}};
         for (int n = 0; n < 16; n++) begin
            logic [31:0] a, b;
            a = $urandom() & lm;
            b = $urandom() & lm;
            drv(1, 1, d, a, b, 0, 0, '0, lref(a, b, d, pl), '1, 2);
            // R4: lane degree above 8 acts as 8
            if (d == 8 && n == 0) drv(1, 1, 12, a, b, 0, 0, '0, lref(a, b, 8, pl), '1, 4);
         end
      end
      idle();

      repeat (5) @(negedge clk);
      chk(q.size() == 0, 3, "results outstanding", 32'(q.size()), 32'h0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL R3 watchdog: actual %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule